// File: doc/BRIEF.md
# Switch CPU Extraction Stream Decoder

This block connects a switch's CPU extraction queue to a host-side packet sink. The queue gives one 32-bit word at a time, together with a flag that says a word is waiting. Control codes travel in-band in that word stream. The block removes them, parses the four-word frame header, and forwards the frame payload as a byte-enabled stream. Each frame arrives with its sideband: source port, CPU queue, tag type and VLAN ID. The trailing 4-byte FCS is read from the queue and dropped.

The control flow is one state machine with four states. `S_HDR` is idle and header capture. `S_PAY` forwards the payload. `S_FCS` discards the check sequence word. `S_DRAIN` flushes the queue after an error. The transitions are:
- S_HDR to S_PAY after the fourth header word, when the length is valid.
- S_HDR to S_DRAIN on a not-ready, abort or end-of-frame code, or when the length is not positive.
- S_PAY to S_FCS when the last payload byte is sent.
- S_PAY to S_HDR on an early end of frame.
- S_PAY to S_DRAIN on abort.
- S_FCS to S_HDR once one data word has been read.
- S_FCS to S_DRAIN on abort.
- S_DRAIN to S_HDR when the word-waiting flag drops.

Top module: `xtr_stream_decoder`

## Requirements
- R1: During and right after reset, `m_valid` is 0, the state is header capture, and no word is read while `in_present` is low.
- R2: Header words are byte-swapped before the fields are taken. Word 1 holds the cell count in bits 14:7 and the tail byte count in bits 20:15. Word 2 holds the port in bits 14:11. Word 3 holds the queue in bits 27:20, the tag type in bit 16 and the VLAN ID in bits 11:0. The sideband outputs carry these fields for every beat of the frame.
- R3: The payload length is CELL_BYTES·cells + tail − 84 bytes. Output byte lane j (`m_data[8j+7:8j]`) carries the j-th byte of the queue word, counting from its most significant byte. Every beat except the last has `m_keep`=4'hF. The last beat keeps only the remaining bytes, in the low lanes.
- R4: The word after an escape code (0x80000006) is data with 4 valid bytes, even when its value equals a code.
- R5: An end-of-frame code (0x80000000..0x80000003) or the pruned code (0x80000004) means the next word is the final word of the frame. That word has 4 minus the code's two low bits valid bytes. If the next word is an escape code, the word after the escape is the final word.
- R6: After the last payload byte, exactly one more data word (the FCS) is read and not forwarded. Decoding of the next frame then starts.
- R7: An abort code (0x80000005) in the payload produces one beat with `m_last`=1, `m_err`=1 and `m_keep`=0. The block then drains.
- R8: A not-ready code (0x80000007) during the header is an error and leads to drain with no output. During the payload it is skipped.
- R9: In drain, words are read and dropped while `in_present` is high, and no beat is produced. The first frame after `in_present` falls decodes normally.
- R10: While `m_valid`=1 and `m_ready`=0, all outputs hold. Outside drain, no queue word is consumed.
- R11: A final word that arrives before the payload length is reached is forwarded as a last beat with `m_err`=1. The block then returns to header capture.
- R12: A header whose payload length is zero or negative leads to drain with no output.
- R13: Frames that follow one another while `in_present` stays high are each decoded in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_present | input | 1 | Queue holds a word |
| in_data | input | 32 | Current queue word |
| in_rd | output | 1 | Pops the current word |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Sink accepts beat |
| m_data | output | 32 | Payload bytes, first byte in lane 0 |
| m_keep | output | 4 | Byte lane enables |
| m_last | output | 1 | Last beat of frame |
| m_err | output | 1 | Frame ended in error |
| m_port | output | 4 | Source port |
| m_queue | output | 8 | CPU queue |
| m_tag | output | 1 | Tag type |
| m_vid | output | 12 | VLAN ID |

## Verification
The bench targets frames whose length is not a multiple of four. There the FCS shares the last payload word, and a decoder that miscounts sends FCS bytes or swallows the next header. It places escapes in the middle of the payload and after an end-of-frame code. A decoder that missed either would lose a frame boundary or emit a code as data. It also drives not-ready in both the header and the payload, aborts, early ends of frame, and zero-length headers, each followed by a clean frame. A design that did not drain, or that drained too long, would corrupt or lose that clean frame. A stalled sink checks that the queue is not popped and the held beat does not change.

// File: rtl/xtr_dec_pkg.sv
package xtr_dec_pkg;

    typedef enum logic [1:0] {
        S_HDR   = 2'd0,
        S_PAY   = 2'd1,
        S_FCS   = 2'd2,
        S_DRAIN = 2'd3
    } xtr_state_e;

    typedef struct packed {
        logic [3:0]  port;
        logic [7:0]  queue;
        logic        tag;
        logic [11:0] vid;
    } xtr_side_t;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [3:0] keep_of(input logic [2:0] n);
        logic [3:0] k;
        case (n)
            3'd0:    k = 4'b0000;
            3'd1:    k = 4'b0001;
            3'd2:    k = 4'b0011;
            3'd3:    k = 4'b0111;
            default: k = 4'b1111;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/xtr_unstuff.sv
module xtr_unstuff #(
    parameter logic [31:0] C_EOF0   = 32'h8000_0000,
    parameter logic [31:0] C_PRUNED = 32'h8000_0004,
    parameter logic [31:0] C_ABORT  = 32'h8000_0005,
    parameter logic [31:0] C_ESC    = 32'h8000_0006,
    parameter logic [31:0] C_NOTRDY = 32'h8000_0007
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc,
    input  logic        clr,
    input  logic [31:0] word,
    output logic        ev_data,
    output logic [2:0]  ev_bytes,
    output logic        ev_final,
    output logic        ev_abort,
    output logic        ev_notrdy,
    output logic        ev_eofc
);

    logic       lit_q;
    logic       pend_q;
    logic [2:0] nb_q;
    logic       is_eof;
    logic       is_esc;
    logic       is_abort;
    logic       is_nr;

    assign is_eof   = (word[31:2] == C_EOF0[31:2]) || (word == C_PRUNED);
    assign is_esc   = (word == C_ESC);
    assign is_abort = (word == C_ABORT);
    assign is_nr    = (word == C_NOTRDY);

    always_comb begin
        ev_data   = 1'b0;
        ev_bytes  = 3'd4;
        ev_final  = 1'b0;
        ev_abort  = 1'b0;
        ev_notrdy = 1'b0;
        ev_eofc   = 1'b0;
        if (lit_q) begin
            ev_data  = 1'b1;
            ev_final = pend_q;
            ev_bytes = pend_q ? nb_q : 3'd4;
        end else if (pend_q) begin
            if (!is_esc) begin
                ev_data  = 1'b1;
                ev_final = 1'b1;
                ev_bytes = nb_q;
            end
        end else if (is_eof) begin
            ev_eofc = 1'b1;
        end else if (is_abort) begin
            ev_abort = 1'b1;
        end else if (is_nr) begin
            ev_notrdy = 1'b1;
        end else if (!is_esc) begin
            ev_data = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lit_q  <= 1'b0;
            pend_q <= 1'b0;
            nb_q   <= 3'd4;
        end else if (clr) begin
            lit_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (acc) begin
            if (lit_q) begin
                lit_q  <= 1'b0;
                pend_q <= 1'b0;
            end else if (pend_q) begin
                if (is_esc) lit_q <= 1'b1;
                else        pend_q <= 1'b0;
            end else if (is_esc) begin
                lit_q <= 1'b1;
            end else if (is_eof) begin
                pend_q <= 1'b1;
                nb_q   <= 3'd4 - {1'b0, word[1:0]};
            end
        end
    end

    // R4: a literal slot covers exactly one word
    a_r4_literal_once: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && lit_q && !clr) |=> !lit_q);

    // R5: the final word closes the pending end-of-frame
    a_r5_final_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ev_final && !clr) |=> !pend_q);

endmodule

// File: rtl/xtr_hdr_parse.sv
module xtr_hdr_parse
    import xtr_dec_pkg::*;
#(
    parameter int CELL_BYTES = 60,
    parameter int LEN_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic             restart,
    input  logic [31:0]      word,
    output logic             hdr_done,
    output logic             len_ok,
    output logic [LEN_W-1:0] pay_len,
    output xtr_side_t        side
);

    localparam int HDR_WORDS = 4;
    localparam int CW        = $clog2(HDR_WORDS);
    localparam int TW        = LEN_W + 2;
    localparam int LEN_ADJ   = 80;
    localparam int FCS_BYTES = 4;

    logic [CW-1:0] cnt_q;
    logic [7:0]    wlen_q;
    logic [5:0]    llen_q;
    logic [31:0]   host;
    logic          unused_host;
    logic [TW-1:0] sum;
    logic [TW-1:0] target;

    assign host        = swap32(word);
    assign unused_host = ^host;
    assign hdr_done    = (cnt_q == CW'(HDR_WORDS - 1));

    assign sum     = TW'(CELL_BYTES) * TW'(wlen_q) + TW'(llen_q);
    assign target  = sum - TW'(LEN_ADJ + FCS_BYTES);
    assign len_ok  = !target[TW-1] && (target != '0);
    assign pay_len = target[LEN_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wlen_q <= '0;
            llen_q <= '0;
            side   <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cap) begin
            cnt_q <= cnt_q + 1'b1;
            unique case (cnt_q)
                CW'(1): begin
                    wlen_q <= host[14:7];
                    llen_q <= host[20:15];
                end
                CW'(2): side.port <= host[14:11];
                CW'(3): begin
                    side.queue <= host[27:20];
                    side.tag   <= host[16];
                    side.vid   <= host[11:0];
                end
                default: ;
            endcase
        end
    end

    // R2: header capture wraps after the fourth word
    a_r2_hdr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && hdr_done && !restart) |=> (cnt_q == '0));

endmodule

// File: rtl/xtr_stream_decoder.sv
module xtr_stream_decoder
    import xtr_dec_pkg::*;
#(
    parameter int          CELL_BYTES = 60,
    parameter int          LEN_W      = 16,
    parameter logic [31:0] C_EOF0     = 32'h8000_0000,
    parameter logic [31:0] C_PRUNED   = 32'h8000_0004,
    parameter logic [31:0] C_ABORT    = 32'h8000_0005,
    parameter logic [31:0] C_ESC      = 32'h8000_0006,
    parameter logic [31:0] C_NOTRDY   = 32'h8000_0007
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_present,
    input  logic [31:0] in_data,
    output logic        in_rd,
    output logic        m_valid,
    input  logic        m_ready,
    output logic [31:0] m_data,
    output logic [3:0]  m_keep,
    output logic        m_last,
    output logic        m_err,
    output logic [3:0]  m_port,
    output logic [7:0]  m_queue,
    output logic        m_tag,
    output logic [11:0] m_vid
);

    xtr_state_e       st_q, nxt;
    logic [LEN_W-1:0] remain_q;
    logic             out_free;

    logic             ev_data, ev_final, ev_abort, ev_notrdy, ev_eofc;
    logic [2:0]       ev_bytes;
    logic             hdr_done, len_ok;
    logic [LEN_W-1:0] pay_len;
    xtr_side_t        side;

    logic             emit, e_last, e_err;
    logic [2:0]       take;

    assign out_free = !m_valid || m_ready;
    assign in_rd    = in_present && ((st_q == S_DRAIN) || out_free);

    xtr_unstuff #(
        .C_EOF0(C_EOF0), .C_PRUNED(C_PRUNED), .C_ABORT(C_ABORT),
        .C_ESC(C_ESC), .C_NOTRDY(C_NOTRDY)
    ) u_unstuff (
        .clk(clk), .rst_n(rst_n), .acc(in_rd), .clr(st_q == S_DRAIN),
        .word(in_data), .ev_data(ev_data), .ev_bytes(ev_bytes),
        .ev_final(ev_final), .ev_abort(ev_abort), .ev_notrdy(ev_notrdy),
        .ev_eofc(ev_eofc)
    );

    xtr_hdr_parse #(.CELL_BYTES(CELL_BYTES), .LEN_W(LEN_W)) u_hdr (
        .clk(clk), .rst_n(rst_n),
        .cap(in_rd && ev_data && (st_q == S_HDR)),
        .restart(st_q != S_HDR), .word(in_data),
        .hdr_done(hdr_done), .len_ok(len_ok), .pay_len(pay_len), .side(side)
    );

    assign m_port  = side.port;
    assign m_queue = side.queue;
    assign m_tag   = side.tag;
    assign m_vid   = side.vid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_HDR;
        else        st_q <= nxt;
    end

    // next state and beat decision
    always_comb begin
        nxt    = st_q;
        emit   = 1'b0;
        e_last = 1'b0;
        e_err  = 1'b0;
        take   = 3'd0;
        unique case (st_q)
            S_HDR: begin
                if (in_rd) begin
                    if (ev_notrdy || ev_abort || ev_eofc)
                        nxt = S_DRAIN;
                    else if (ev_data && hdr_done)
                        nxt = len_ok ? S_PAY : S_DRAIN;
                end
            end
            S_PAY: begin
                if (in_rd) begin
                    if (ev_abort) begin
                        emit   = 1'b1;
                        e_last = 1'b1;
                        e_err  = 1'b1;
                        nxt    = S_DRAIN;
                    end else if (ev_data) begin
                        emit = 1'b1;
                        take = (remain_q < LEN_W'(ev_bytes)) ? remain_q[2:0] : ev_bytes;
                        if (remain_q <= LEN_W'(ev_bytes)) begin
                            e_last = 1'b1;
                            nxt    = S_FCS;
                        end else if (ev_final) begin
                            e_last = 1'b1;
                            e_err  = 1'b1;
                            nxt    = S_HDR;
                        end
                    end
                end
            end
            S_FCS: begin
                if (in_rd) begin
                    if (ev_abort)     nxt = S_DRAIN;
                    else if (ev_data) nxt = S_HDR;
                end
            end
            S_DRAIN: begin
                if (!in_present) nxt = S_HDR;
            end
            default: nxt = S_HDR;
        endcase
    end

    // outputs and length tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            m_valid  <= 1'b0;
            m_data   <= '0;
            m_keep   <= '0;
            m_last   <= 1'b0;
            m_err    <= 1'b0;
        end else begin
            if ((st_q == S_HDR) && (nxt == S_PAY))
                remain_q <= pay_len;
            else if (emit)
                remain_q <= remain_q - LEN_W'(take);
            if (emit) begin
                m_valid <= 1'b1;
                m_data  <= swap32(in_data);
                m_keep  <= keep_of(take);
                m_last  <= e_last;
                m_err   <= e_err;
            end else if (m_ready) begin
                m_valid <= 1'b0;
            end
        end
    end

    // R10: a stalled beat and its sideband hold
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_keep)
            && $stable(m_last) && $stable(m_err) && $stable(m_port)
            && $stable(m_queue) && $stable(m_tag) && $stable(m_vid)));

    // R3: only the last beat may be partial
    a_r3_mid_full: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_last) |-> (m_keep == 4'hF));

    // R7: an error beat always closes the frame
    a_r7_err_last: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_err) |-> m_last);

    // R9: drain never starts a beat
    a_r9_drain_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DRAIN) |=> !$rose(m_valid));

    // R6: the FCS word never starts a beat
    a_r6_fcs_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_FCS) |=> !$rose(m_valid));

endmodule

// File: tb/xtr_stream_decoder_bench.sv
module xtr_stream_decoder_bench;

    localparam int          CELL   = 60;
    localparam logic [31:0] EOF0   = 32'h8000_0000;
    localparam logic [31:0] ABORT  = 32'h8000_0005;
    localparam logic [31:0] ESC    = 32'h8000_0006;
    localparam logic [31:0] NOTRDY = 32'h8000_0007;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        in_present, in_rd;
    logic [31:0] in_data;
    logic        m_valid, m_ready, m_last, m_err, m_tag;
    logic [31:0] m_data;
    logic [3:0]  m_keep, m_port;
    logic [7:0]  m_queue;
    logic [11:0] m_vid;

    logic [31:0] st_mem [0:4095];
    int st_n   = 0;
    int st_idx = 0;

    assign in_present = (st_idx < st_n);
    assign in_data    = (st_idx < st_n) ? st_mem[st_idx] : 32'h0;

    always @(posedge clk) if (rst_n && in_rd && in_present) st_idx <= st_idx + 1;

    int ready_mode = 0;
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            0:       m_ready <= 1'b1;
            1:       m_ready <= (cyc % 3) != 0;
            default: m_ready <= 1'b0;
        endcase
    end

    logic [7:0] cap_b [0:8191];
    int cap_n = 0, cap_lasts = 0, cap_errs = 0;
    logic [3:0]  lkeep;
    logic [24:0] lside;
    always @(posedge clk) begin
        if (rst_n && m_valid && m_ready) begin
            for (int j = 0; j < 4; j++)
                if (m_keep[j]) begin
                    cap_b[cap_n] = m_data[8*j +: 8];
                    cap_n++;
                end
            if (m_last) begin
                cap_lasts++;
                lkeep = m_keep;
            end
            if (m_err) cap_errs++;
            lside = {m_port, m_queue, m_tag, m_vid};
        end
    end

    xtr_stream_decoder u_xtr_stream_decoder (
        .clk(clk), .rst_n(rst_n), .in_present(in_present), .in_data(in_data),
        .in_rd(in_rd), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_keep(m_keep), .m_last(m_last), .m_err(m_err), .m_port(m_port),
        .m_queue(m_queue), .m_tag(m_tag), .m_vid(m_vid)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    logic [7:0] exp_b [0:8191];
    int exp_n, exp_l, exp_e, base_n, base_l, base_e, seed = 3;
    logic [24:0] exp_side;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exv);
        end
    endtask

    function automatic logic [31:0] bsw(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic push(input logic [31:0] w);
        st_mem[st_n] = w;
        st_n++;
    endtask

    task automatic push_data(input logic [31:0] w);
        if (w[31:3] == EOF0[31:3]) push(ESC);
        push(w);
    endtask

    task automatic scn_begin();
        base_n = cap_n; base_l = cap_lasts; base_e = cap_errs;
        exp_n = 0; exp_l = 0; exp_e = 0;
    endtask

    task automatic send_frame(input int hlen, input int blen, input int port,
                              input int q, input int tg, input int vid,
                              input int esc_at, input int nr_at,
                              input int abort_at, input bit hdr_nr);
        logic [7:0] fb [0:511];
        int nw, vb, wl, ll, fwd;
        logic [31:0] h1, h2, h3, w;
        nw = (blen + 3) / 4;
        vb = (blen % 4 == 0) ? 4 : blen % 4;
        for (int i = 0; i < nw * 4; i++) fb[i] = (i < blen) ? 8'(seed + i * 13 + 1) : 8'h00;
        seed += 37;
        if (esc_at >= 0) begin
            fb[4*esc_at] = 8'h80; fb[4*esc_at+1] = 8'h00;
            fb[4*esc_at+2] = 8'h00; fb[4*esc_at+3] = 8'h06;
        end
        wl = (hlen + 80) / CELL;
        ll = (hlen + 80) % CELL;
        h1 = (32'(wl) << 7) | (32'(ll) << 15) | 32'h0040_0001;
        h2 = (32'(port) << 11) | 32'h0000_0408 | 32'h0001_0000;
        h3 = (32'(q) << 20) | (32'(tg) << 16) | 32'(vid) | 32'h1000_2000;
        push_data(bsw(32'h1234_5678));
        push_data(bsw(h1));
        if (hdr_nr) push(NOTRDY);
        push_data(bsw(h2));
        push_data(bsw(h3));
        for (int k = 0; k < nw; k++) begin
            if (k == nr_at) push(NOTRDY);
            if (k == abort_at) begin
                push(ABORT);
                push(32'h1122_3344); push(32'h5566_7788); push(EOF0);
                break;
            end
            if (k == nw - 1) push(EOF0 + 32'(4 - vb));
            w = {fb[4*k], fb[4*k+1], fb[4*k+2], fb[4*k+3]};
            push_data(w);
        end
        fwd = 0;
        if (hdr_nr || hlen - 4 <= 0) begin
            fwd = 0;
        end else if (abort_at >= 0) begin
            fwd = 4 * abort_at; exp_l++; exp_e++;
        end else if (blen < hlen - 4) begin
            fwd = blen; exp_l++; exp_e++;
        end else begin
            fwd = hlen - 4; exp_l++;
        end
        for (int i = 0; i < fwd; i++) begin
            exp_b[exp_n] = fb[i];
            exp_n++;
        end
        if (!hdr_nr && hlen - 4 > 0) exp_side = {4'(port), 8'(q), 1'(tg), 12'(vid)};
    endtask

    task automatic wait_idle();
        int t = 0;
        while ((st_idx < st_n || m_valid) && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_run(input string req);
        int bad = 0, first = -1;
        wait_idle();
        chk((cap_n - base_n) == exp_n, req, "forwarded byte count", cap_n - base_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n - base_n; i++)
            if (cap_b[base_n + i] !== exp_b[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        chk(bad == 0, req, "byte mismatches (first index)", first, -1);
        chk((cap_lasts - base_l) == exp_l, req, "last beats", cap_lasts - base_l, exp_l);
        chk((cap_errs - base_e) == exp_e, req, "error beats", cap_errs - base_e, exp_e);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(m_valid == 1'b0, "R1", "m_valid in reset", m_valid, 0);
        chk(in_rd == 1'b0, "R1", "in_rd in reset", in_rd, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(m_valid == 1'b0, "R1", "m_valid after reset", m_valid, 0);
    endtask

    task automatic t_basic();
        scn_begin();
        send_frame(64, 64, 5, 8'h9C, 1, 12'hABC, -1, -1, -1, 1'b0);
        check_run("R3 R6");
        chk(lside == exp_side, "R2", "sideband fields", lside, exp_side);
    endtask

    task automatic t_unaligned();
        ready_mode = 1;
        scn_begin();
        send_frame(61, 61, 9, 8'h03, 0, 12'h005, -1, -1, -1, 1'b0);
        check_run("R3 R5 R10");
        chk(lkeep == 4'b0001, "R3", "last beat keep", lkeep, 4'b0001);
        ready_mode = 0;
    endtask

    task automatic t_escape_b2b();
        scn_begin();
        send_frame(68, 68, 2, 8'h41, 0, 12'h100, 3, -1, -1, 1'b0);
        send_frame(70, 70, 14, 8'hF0, 1, 12'hFFF, 17, -1, -1, 1'b0);
        check_run("R4 R5 R13");
        chk(lside == exp_side, "R13", "second frame sideband", lside, exp_side);
    endtask

    task automatic t_pay_notready();
        scn_begin();
        send_frame(64, 64, 1, 8'h22, 0, 12'h321, -1, 6, -1, 1'b0);
        check_run("R8");
    endtask

    task automatic t_hdr_error();
        scn_begin();
        send_frame(64, 64, 3, 8'h11, 0, 12'h111, -1, -1, -1, 1'b1);
        check_run("R8 R9");
        scn_begin();
        send_frame(66, 66, 7, 8'h77, 1, 12'h777, -1, -1, -1, 1'b0);
        check_run("R9");
        chk(lside == exp_side, "R9", "sideband after drain", lside, exp_side);
    endtask

    task automatic t_abort();
        scn_begin();
        send_frame(64, 64, 4, 8'h44, 0, 12'h044, -1, -1, 5, 1'b0);
        check_run("R7");
        chk(lkeep == 4'b0000, "R7", "abort beat keep", lkeep, 0);
        scn_begin();
        send_frame(65, 65, 6, 8'h66, 0, 12'h066, -1, -1, -1, 1'b0);
        check_run("R7 R9");
    endtask

    task automatic t_early_eof();
        scn_begin();
        send_frame(100, 41, 8, 8'h88, 1, 12'h888, -1, -1, -1, 1'b0);
        check_run("R11");
        scn_begin();
        send_frame(64, 64, 10, 8'h10, 0, 12'h010, -1, -1, -1, 1'b0);
        check_run("R11");
    endtask

    task automatic t_short();
        scn_begin();
        send_frame(4, 4, 11, 8'h01, 0, 12'h001, -1, -1, -1, 1'b0);
        check_run("R12");
        scn_begin();
        send_frame(72, 72, 12, 8'h02, 1, 12'h002, -1, -1, -1, 1'b0);
        check_run("R12");
    endtask

    task automatic t_stall();
        int idx0;
        logic [31:0] d0;
        ready_mode = 2;
        scn_begin();
        send_frame(64, 64, 13, 8'h55, 0, 12'h555, -1, -1, -1, 1'b0);
        repeat (30) @(negedge clk);
        chk(m_valid == 1'b1, "R10", "beat waiting", m_valid, 1);
        idx0 = st_idx;
        d0 = m_data;
        repeat (10) @(negedge clk);
        chk(st_idx == idx0, "R10", "queue index under stall", st_idx, idx0);
        chk(m_data == d0, "R10", "held data", m_data, d0);
        ready_mode = 0;
        check_run("R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_unaligned();
        t_escape_b2b();
        t_pay_notready();
        t_hdr_error();
        t_abort();
        t_early_eof();
        t_short();
        t_stall();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule